// File: doc/BRIEF.md
# Card Access Strobe Timing Sequencer

This block times a single read or write cycle to a removable card through one mapped window. A one-cycle start pulse, together with a direction bit and the window's option word, launches the access. The sequencer takes three phase lengths, counted in bus clocks, from fixed fields of that option word. It then walks an address-setup phase, a strobe phase and a hold phase in that order. During the strobe phase it pulls exactly one active-low strobe. The strobe is a memory output-enable or write-enable, or an I/O read or write strobe when the option word marks the window as I/O space.

The bus monitor aborts any transfer that runs too long. So, before it starts, the sequencer adds up the three phase lengths and refuses an access whose sum reaches the bus-monitor ceiling. In that case it raises a one-cycle timeout flag and leaves the bus untouched. Address and data steering sit outside this block. The surrounding logic holds the address stable from the start pulse until `done`.

Top module: `cas_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, all four strobes are high and `busy`, `done` and `timeout` are low.
- R2: When start is accepted, the option word supplies the lengths: setup from bits 15..12, strobe length from bits 11..7 and hold from bits 17..16. Bits 4..3 give the window kind. All other bits have no effect on the outputs.
- R3: An accepted access occupies the setup cycles, then the strobe cycles, then the hold cycles, back to back. A setup or hold length of zero removes that phase, and no idle cycle is inserted in its place.
- R4: A strobe-length field of zero produces a strobe phase of exactly one cycle.
- R5: For a memory window (window kind other than 2'b11), a read (`wr`=0) drives `mem_oe_n` low and a write drives `mem_we_n` low, in every strobe-phase cycle. Both I/O strobes stay high.
- R6: For an I/O window (window kind 2'b11), a read drives `io_rd_n` low and a write drives `io_wr_n` low, in every strobe-phase cycle. Both memory strobes stay high.
- R7: At most one strobe is low in any cycle. No strobe is low during setup, hold or idle cycles.
- R8: `done` is a one-cycle pulse in the final busy cycle of each accepted access.
- R9: A start pulse is acted on only when the sequencer is idle. While `busy` is high, start has no effect on the outputs.
- R10: The option word and `wr` are used only in the cycle in which start is accepted. Later changes do not alter the access in progress.
- R11: If setup + effective strobe length + hold is at least `BUS_LIMIT`, `timeout` is high for the one cycle after the start, and `busy` stays low.
- R12: For an accepted access, `busy` is high from the cycle after start through the cycle carrying `done`, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Access request, sampled on each rising edge |
| wr | input | 1 | Direction: 1 write, 0 read |
| opt | input | OPT_W | Option word of the selected window |
| mem_oe_n | output | 1 | Memory output-enable strobe, active low |
| mem_we_n | output | 1 | Memory write-enable strobe, active low |
| io_rd_n | output | 1 | I/O read strobe, active low |
| io_wr_n | output | 1 | I/O write strobe, active low |
| busy | output | 1 | Access in progress |
| done | output | 1 | Final cycle of the access |
| timeout | output | 1 | Programmed access rejected as too long |

## Verification
With the default field widths, the longest programmable access is 15 + 31 + 3 = 49 clocks. That is below the default ceiling of 60, so the ceiling can never be reached and the design folds the comparison away. The bench therefore builds the block with `BUS_LIMIT` = 20 and the default field positions. This makes the rejection path reachable, and it puts the exact boundary between a sum of 19 (runs) and 20 (rejected) within a few directed accesses. A behavioural phase queue in the bench predicts every output on every cycle. It covers back-to-back starts, starts held high through an access, and option words rewritten mid-access.

// File: rtl/cas_seq_pkg.sv
package cas_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } cas_phase_e;

    localparam logic [1:0] KIND_IO = 2'b11;

    function automatic int cas_max3(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/cas_opt_decode.sv
module cas_opt_decode
    import cas_seq_pkg::*;
#(
    parameter int OPT_W     = 32,
    parameter int SETUP_LSB = 12,
    parameter int SETUP_W   = 4,
    parameter int STRB_LSB  = 7,
    parameter int STRB_W    = 5,
    parameter int HOLD_LSB  = 16,
    parameter int HOLD_W    = 2,
    parameter int KIND_LSB  = 3,
    parameter int BUS_LIMIT = 60
) (
    input  logic [OPT_W-1:0]   opt,
    output logic [SETUP_W-1:0] setup_len,
    output logic [STRB_W-1:0]  strb_len,
    output logic [HOLD_W-1:0]  hold_len,
    output logic               is_io,
    output logic               over_limit
);

    localparam int MAX_TOTAL = (2**SETUP_W - 1) + (2**STRB_W - 1) + (2**HOLD_W - 1);
    localparam int CNT_W     = cas_max3(SETUP_W, STRB_W, HOLD_W);
    localparam int TOT_W     = CNT_W + 2;

    logic [STRB_W-1:0] strb_raw;

    always_comb begin
        setup_len = opt[SETUP_LSB +: SETUP_W];
        strb_raw  = opt[STRB_LSB +: STRB_W];
        hold_len  = opt[HOLD_LSB +: HOLD_W];
        is_io     = (opt[KIND_LSB +: 2] == KIND_IO);
        strb_len  = (strb_raw == '0) ? STRB_W'(1) : strb_raw;
    end

    generate
        if (MAX_TOTAL < BUS_LIMIT) begin : g_unreachable
            assign over_limit = 1'b0;
        end else begin : g_compare
            localparam logic [TOT_W-1:0] LIM_V = TOT_W'(BUS_LIMIT);
            logic [TOT_W-1:0] total;
            always_comb begin
                total      = TOT_W'(setup_len) + TOT_W'(strb_len) + TOT_W'(hold_len);
                over_limit = (total >= LIM_V);
            end
        end
    endgenerate

endmodule

// File: rtl/cas_phase_next.sv
module cas_phase_next
    import cas_seq_pkg::*;
#(
    parameter int CNT_W  = 5,
    parameter int STRB_W = 5,
    parameter int HOLD_W = 2
) (
    input  cas_phase_e         phase,
    input  logic [CNT_W-1:0]   cnt,
    input  logic [STRB_W-1:0]  strb_len,
    input  logic [HOLD_W-1:0]  hold_len,
    output logic               last,
    output cas_phase_e         nxt_phase,
    output logic [CNT_W-1:0]   nxt_len,
    output logic               final_cyc
);

    always_comb begin
        last      = (phase != PH_IDLE) && (cnt == CNT_W'(1));
        nxt_phase = PH_IDLE;
        nxt_len   = '0;
        case (phase)
            PH_SETUP: begin
                nxt_phase = PH_STROBE;
                nxt_len   = CNT_W'(strb_len);
            end
            PH_STROBE: begin
                if (hold_len != '0) begin
                    nxt_phase = PH_HOLD;
                    nxt_len   = CNT_W'(hold_len);
                end
            end
            default: begin
                nxt_phase = PH_IDLE;
                nxt_len   = '0;
            end
        endcase
        final_cyc = last && (nxt_phase == PH_IDLE);
    end

endmodule

// File: rtl/cas_strobe_drive.sv
module cas_strobe_drive (
    input  logic strobe_on,
    input  logic wr,
    input  logic is_io,
    output logic mem_oe_n,
    output logic mem_we_n,
    output logic io_rd_n,
    output logic io_wr_n
);

    always_comb begin
        mem_oe_n = !(strobe_on && !is_io && !wr);
        mem_we_n = !(strobe_on && !is_io &&  wr);
        io_rd_n  = !(strobe_on &&  is_io && !wr);
        io_wr_n  = !(strobe_on &&  is_io &&  wr);
    end

endmodule

// File: rtl/cas_seq.sv
module cas_seq
    import cas_seq_pkg::*;
#(
    parameter int OPT_W     = 32,
    parameter int SETUP_LSB = 12,
    parameter int SETUP_W   = 4,
    parameter int STRB_LSB  = 7,
    parameter int STRB_W    = 5,
    parameter int HOLD_LSB  = 16,
    parameter int HOLD_W    = 2,
    parameter int KIND_LSB  = 3,
    parameter int BUS_LIMIT = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             wr,
    input  logic [OPT_W-1:0] opt,
    output logic             mem_oe_n,
    output logic             mem_we_n,
    output logic             io_rd_n,
    output logic             io_wr_n,
    output logic             busy,
    output logic             done,
    output logic             timeout
);

    localparam int CNT_W = cas_max3(SETUP_W, STRB_W, HOLD_W);

    typedef struct packed {
        cas_phase_e         phase;
        logic [CNT_W-1:0]   cnt;
        logic [STRB_W-1:0]  strb;
        logic [HOLD_W-1:0]  hold;
        logic               wr;
        logic               io;
        logic               timeout;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic [SETUP_W-1:0] dec_setup;
    logic [STRB_W-1:0]  dec_strb;
    logic [HOLD_W-1:0]  dec_hold;
    logic               dec_io;
    logic               dec_over;

    logic               ph_last;
    cas_phase_e         ph_nxt;
    logic [CNT_W-1:0]   ph_nxt_len;
    logic               ph_final;

    cas_opt_decode #(
        .OPT_W     (OPT_W),
        .SETUP_LSB (SETUP_LSB),
        .SETUP_W   (SETUP_W),
        .STRB_LSB  (STRB_LSB),
        .STRB_W    (STRB_W),
        .HOLD_LSB  (HOLD_LSB),
        .HOLD_W    (HOLD_W),
        .KIND_LSB  (KIND_LSB),
        .BUS_LIMIT (BUS_LIMIT)
    ) u_decode (
        .opt        (opt),
        .setup_len  (dec_setup),
        .strb_len   (dec_strb),
        .hold_len   (dec_hold),
        .is_io      (dec_io),
        .over_limit (dec_over)
    );

    cas_phase_next #(
        .CNT_W  (CNT_W),
        .STRB_W (STRB_W),
        .HOLD_W (HOLD_W)
    ) u_next (
        .phase     (st_q.phase),
        .cnt       (st_q.cnt),
        .strb_len  (st_q.strb),
        .hold_len  (st_q.hold),
        .last      (ph_last),
        .nxt_phase (ph_nxt),
        .nxt_len   (ph_nxt_len),
        .final_cyc (ph_final)
    );

    cas_strobe_drive u_drive (
        .strobe_on (st_q.phase == PH_STROBE),
        .wr        (st_q.wr),
        .is_io     (st_q.io),
        .mem_oe_n  (mem_oe_n),
        .mem_we_n  (mem_we_n),
        .io_rd_n   (io_rd_n),
        .io_wr_n   (io_wr_n)
    );

    always_comb begin
        st_d         = st_q;
        st_d.timeout = 1'b0;
        if (st_q.phase == PH_IDLE) begin
            if (start) begin
                if (dec_over) begin
                    st_d.timeout = 1'b1;
                end else begin
                    st_d.wr   = wr;
                    st_d.io   = dec_io;
                    st_d.strb = dec_strb;
                    st_d.hold = dec_hold;
                    if (dec_setup != '0) begin
                        st_d.phase = PH_SETUP;
                        st_d.cnt   = CNT_W'(dec_setup);
                    end else begin
                        st_d.phase = PH_STROBE;
                        st_d.cnt   = CNT_W'(dec_strb);
                    end
                end
            end
        end else if (ph_last) begin
            st_d.phase = ph_nxt;
            st_d.cnt   = ph_nxt_len;
        end else begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy    = (st_q.phase != PH_IDLE);
    assign done    = ph_final;
    assign timeout = st_q.timeout;

endmodule

// File: rtl/cas_seq_chk.sv
module cas_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic mem_oe_n,
    input logic mem_we_n,
    input logic io_rd_n,
    input logic io_wr_n,
    input logic busy,
    input logic done,
    input logic timeout
);

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!mem_oe_n, !mem_we_n, !io_rd_n, !io_wr_n}) <= 1); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mem_oe_n && mem_we_n && io_rd_n && io_wr_n)); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy); // R12

    AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy); // R9

    AST_TIMEOUT_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> !busy); // R11

endmodule

bind cas_seq cas_seq_chk u_cas_seq_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_oe_n (mem_oe_n),
    .mem_we_n (mem_we_n),
    .io_rd_n  (io_rd_n),
    .io_wr_n  (io_wr_n),
    .busy     (busy),
    .done     (done),
    .timeout  (timeout)
);

// File: tb/cas_seq_bench.sv
`timescale 1ns/1ps
module cas_seq_bench;

    localparam int LIM = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        wr = 1'b0;
    logic [31:0] opt = '0;
    logic        mem_oe_n, mem_we_n, io_rd_n, io_wr_n, busy, done, timeout;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    cas_seq #(.BUS_LIMIT(LIM)) u_cas_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .wr(wr), .opt(opt),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .io_rd_n(io_rd_n),
        .io_wr_n(io_wr_n), .busy(busy), .done(done), .timeout(timeout)
    );

    // behavioural model: a queue of phase codes, one entry per busy cycle
    // (1 setup, 2 strobe, 3 hold)
    int  ph_q[$];
    bit  exp_to;
    bit  m_wr, m_io;
    int  ms, ml, mh;

    always @(posedge clk) begin
        if (!rst_n) begin
            ph_q.delete();
            exp_to = 0;
        end else begin
            exp_to = 0;
            if (ph_q.size() > 0) begin
                void'(ph_q.pop_front());
            end else if (start) begin
                ms = int'(opt[15:12]);
                ml = int'(opt[11:7]);
                mh = int'(opt[17:16]);
                if (ml == 0) ml = 1;
                if (ms + ml + mh >= LIM) begin
                    exp_to = 1;
                end else begin
                    m_wr = wr;
                    m_io = (opt[4:3] == 2'b11);
                    repeat (ms) ph_q.push_back(1);
                    repeat (ml) ph_q.push_back(2);
                    repeat (mh) ph_q.push_back(3);
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            bit e_busy, e_done, s_on;
            logic [3:0] e_str, a_str;
            string rq;
            e_busy = ph_q.size() > 0;
            e_done = ph_q.size() == 1;
            s_on   = e_busy && ph_q[0] == 2;
            e_str  = {!(s_on && !m_io && !m_wr), !(s_on && !m_io && m_wr),
                      !(s_on && m_io && !m_wr),  !(s_on && m_io && m_wr)};
            a_str  = {mem_oe_n, mem_we_n, io_rd_n, io_wr_n};
            if (!rst_n) begin
                chk(busy == 0 && done == 0 && timeout == 0 && a_str == 4'hf,
                    "R1 reset state", int'({busy, done, timeout, a_str}), 15);
            end else begin
                chk(busy == e_busy, "R12 busy", int'(busy), int'(e_busy));
                chk(done == e_done, "R8 done", int'(done), int'(e_done));
                chk(timeout == exp_to, "R11 timeout", int'(timeout), int'(exp_to));
                rq = m_io ? "R6 strobes" : "R5 strobes";
                chk(a_str == e_str, rq, int'(a_str), int'(e_str));
                chk($countones(~a_str) <= 1, "R7 single strobe", $countones(~a_str), 1);
            end
        end
    end

    function automatic logic [31:0] mk(input int s, input int l, input int h,
                                       input logic [1:0] k, input logic [13:0] junk);
        logic [31:0] v;
        v        = '0;
        v[31:18] = junk;
        v[17:16] = h[1:0];
        v[15:12] = s[3:0];
        v[11:7]  = l[4:0];
        v[6:5]   = junk[1:0];
        v[4:3]   = k;
        v[2:0]   = junk[4:2];
        return v;
    endfunction

    task automatic launch(input logic [31:0] o, input logic w);
        @(negedge clk);
        opt = o; wr = w; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R5: memory read, all three phases, junk in unused bits
        launch(mk(2, 3, 1, 2'b00, 14'h2a5a), 1'b0); wait_idle();
        // R3: zero setup and zero hold are skipped, memory write
        launch(mk(0, 4, 0, 2'b01, 14'h0000), 1'b1); wait_idle();
        // R4: strobe field zero gives one strobe cycle
        launch(mk(1, 0, 2, 2'b00, 14'h3fff), 1'b0); wait_idle();
        // R6: I/O window read and write
        launch(mk(1, 2, 1, 2'b11, 14'h1234), 1'b0); wait_idle();
        launch(mk(0, 3, 3, 2'b11, 14'h0f0f), 1'b1); wait_idle();
        // R6 boundary: kind 2'b10 is still memory
        launch(mk(1, 1, 1, 2'b10, 14'h0000), 1'b1); wait_idle();

        // R9 R10: starts while busy ignored, option word rewritten mid-access
        launch(mk(2, 3, 1, 2'b00, 14'h0000), 1'b0);
        opt = mk(0, 1, 0, 2'b11, 14'h1111); wr = 1'b1; start = 1'b1;
        repeat (3) @(negedge clk);
        start = 1'b0;
        wait_idle();

        // R11: sum 19 runs, sum 20 and 25 rejected
        launch(mk(5, 11, 3, 2'b00, 14'h0000), 1'b0); wait_idle();
        launch(mk(6, 11, 3, 2'b00, 14'h0000), 1'b1); wait_idle();
        launch(mk(15, 10, 0, 2'b11, 14'h0000), 1'b0); wait_idle();

        // R8 R12: start held high, back-to-back single-cycle accesses
        @(negedge clk);
        opt = mk(0, 1, 0, 2'b00, 14'h0000); wr = 1'b0; start = 1'b1;
        repeat (12) @(negedge clk);
        start = 1'b0;
        wait_idle();

        for (int i = 0; i < 80; i++) begin
            launch(mk($urandom_range(0, 15), $urandom_range(0, 31), $urandom_range(0, 3),
                      2'($urandom_range(0, 3)), 14'($urandom)), 1'($urandom_range(0, 1)));
            if ($urandom_range(0, 1) == 1) begin
                opt = 32'($urandom); start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
            wait_idle();
        end

        repeat (4) @(negedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule